// File: doc/BRIEF.md
# Multi-source reset sequencing controller

This block produces the internal reset of a small microcontroller core. It runs on the oscillator clock and divides it into machine cycles of twelve oscillator periods. Three sources can start a reset: the external reset pin, a watchdog overflow strobe, and a CAN wake-up event that arrives while the device is powered down. Each source has its own pulse length. The block drives a request to pull the reset pin high, a reset for the core, a reset for the CAN controller, and forcing levels that hold the address-latch and program-store strobes high.

The external pin is synchronised and only counts as a reset once it has stayed high for two machine cycles. Watchdog and wake-up events start an internal pin pull-up pulse. When a new event arrives during a running pulse, the pulse is extended and never shortened. The core reset stays on while the pulse runs or while the qualified pin stays high, whatever the level on the pin. It is released only on a machine-cycle boundary. A reset caused only by the wake-up leaves the CAN controller running. RAM is never touched.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The machine-cycle counter runs freely from reset release and is cleared only by `por_n`. After `por_n` rises (two-flop release), machine-cycle boundaries fall at clock edges 14, 26, 38, and so on, counted from the rise. The core reset only ever falls at such an edge.
- R2: `pin_rst` passes through a two-flop synchroniser. It qualifies after 24 consecutive high samples. If the pin is first high at clock edge k and stays high for N ≥ 24 edges, `core_rst` is high after edge k+26. If N < 24, no reset results.
- R3: A `wdt_ovf` strobe sampled at edge e holds `pin_pullup` high for exactly 3 machine cycles (36 clocks), from edge e onward.
- R4: A `can_wake` event sampled at edge e while `pwr_down` is high holds `pin_pullup` high for WAKE_MC machine cycles (default 6144), from edge e onward.
- R5: A `can_wake` event while `pwr_down` is low has no effect: no pull-up pulse and no reset.
- R6: An event that arrives during a running pulse sets the remaining length to the larger of the current remainder and the length of the new source.
- R7: `core_rst` rises one clock after `pin_pullup` or the qualified pin goes high, whatever level `pin_rst` has. It falls at the first machine-cycle boundary at which both sources were already off during the preceding clock.
- R8: `can_rst` is high only while `core_rst` is high. It is high from the watchdog strobe or the pin qualification until release. A reset started only by a wake-up leaves `can_rst` low throughout.
- R9: `ale_force` and `psen_force` are high exactly while `core_rst` is high.
- R10: While `por_n` is low, and afterwards with idle inputs, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low |
| pin_rst | input | 1 | Level seen on the external reset pin |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| can_wake | input | 1 | CAN wake-up event |
| pwr_down | input | 1 | Device is in power-down |
| pin_pullup | output | 1 | Request to pull the reset pin high |
| core_rst | output | 1 | Reset to the processor core |
| can_rst | output | 1 | Reset to the CAN controller |
| ale_force | output | 1 | Holds the address-latch strobe high |
| psen_force | output | 1 | Holds the program-store strobe high |

## Verification
The assertions check on every cycle that a pull-up pulse only starts after a watchdog strobe or a qualified wake-up, and that an ignored wake-up starts nothing. They also check that the core reset follows an active pulse one clock later, that the CAN reset never appears without the core reset, and that release happens only at a machine-cycle boundary. Only the bench scenarios can show the exact pulse lengths, the 24-sample qualification threshold with its one-short counterpart, the extension of one pulse by another in both orders, and the CAN controller being spared on a wake-up reset. The bench shows these by sweeping the strobe phase and the pin-hold length against arithmetically predicted edge numbers.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef struct packed {
    logic wdt;
    logic wake;
  } rst_req_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rst_mc_tick.sv
module rst_mc_tick #(
  parameter int PER = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [W-1:0] LAST = W'(PER - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int SYNC = 2,
  parameter int QLIM = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_ok
);
  localparam int QW = $clog2(QLIM + 1);
  localparam logic [QW-1:0] QMAX = QW'(QLIM);

  logic [SYNC-1:0] sq;
  logic [QW-1:0]   qcnt_q, qcnt_d;

  genvar g;
  generate
    for (g = 0; g < SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sq[0] <= 1'b0;
          else        sq[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sq[g] <= 1'b0;
          else        sq[g] <= sq[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    if (!sq[SYNC-1])        qcnt_d = '0;
    else if (qcnt_q == QMAX) qcnt_d = qcnt_q;
    else                     qcnt_d = qcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qcnt_q <= '0;
    else        qcnt_q <= qcnt_d;
  end

  assign pin_ok = (qcnt_q == QMAX);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
  import rst_seq_pkg::*;
#(
  parameter int WDT_LEN  = 36,
  parameter int WAKE_LEN = 73728
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rst_req_t req,
  output logic     active
);
  localparam int MAXL = int'(max2(WDT_LEN, WAKE_LEN));
  localparam int RW   = $clog2(MAXL + 1);
  localparam logic [RW-1:0] WDT_V  = RW'(WDT_LEN);
  localparam logic [RW-1:0] WAKE_V = RW'(WAKE_LEN);

  logic [RW-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = (rem_q != '0) ? rem_q - 1'b1 : '0;
    if (req.wdt  && (rem_d < WDT_V))  rem_d = WDT_V;
    if (req.wake && (rem_d < WAKE_V)) rem_d = WAKE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign active = (rem_q != '0);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int EXT_MC     = 2,
  parameter int WDT_MC     = 3,
  parameter int WAKE_MC    = 6144,
  parameter int SYNC       = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_rst,
  input  logic wdt_ovf,
  input  logic can_wake,
  input  logic pwr_down,
  output logic pin_pullup,
  output logic core_rst,
  output logic can_rst,
  output logic ale_force,
  output logic psen_force
);
  localparam int QLIM     = EXT_MC * OSC_PER_MC;
  localparam int WDT_LEN  = WDT_MC * OSC_PER_MC;
  localparam int WAKE_LEN = WAKE_MC * OSC_PER_MC;

  logic [1:0] rs_q;
  logic       rst_n;
  logic       tick, pin_ok, pulse_on, hold;
  logic       core_q, core_d, canq_q, canq_d;
  rst_req_t   req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  rst_mc_tick #(.PER(OSC_PER_MC)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rst_pin_qual #(.SYNC(SYNC), .QLIM(QLIM)) i_qual (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_rst), .pin_ok(pin_ok)
  );

  assign req.wdt  = wdt_ovf;
  assign req.wake = can_wake & pwr_down;

  rst_pulse_gen #(.WDT_LEN(WDT_LEN), .WAKE_LEN(WAKE_LEN)) i_pulse (
    .clk(clk), .rst_n(rst_n), .req(req), .active(pulse_on)
  );

  assign hold = pulse_on | pin_ok;

  always_comb begin
    core_d = core_q;
    if (hold)      core_d = 1'b1;
    else if (tick) core_d = 1'b0;
    canq_d = canq_q;
    if (wdt_ovf | pin_ok) canq_d = 1'b1;
    else if (tick & ~hold) canq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b0;
      canq_q <= 1'b0;
    end else begin
      core_q <= core_d;
      canq_q <= canq_d;
    end
  end

  assign pin_pullup = pulse_on;
  assign core_rst   = core_q;
  assign can_rst    = core_q & canq_q;
  assign ale_force  = core_q;
  assign psen_force = core_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int OSC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic wdt_ovf,
  input logic can_wake,
  input logic pwr_down,
  input logic pin_pullup,
  input logic core_rst,
  input logic can_rst
);
  localparam int W = $clog2(OSC);
  localparam logic [W-1:0] LAST = W'(OSC - 1);

  logic [W-1:0] ph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ph <= '0;
    else if (ph == LAST) ph <= '0;
    else                 ph <= ph + 1'b1;
  end

  // R1 / R7: release only at a machine-cycle boundary
  a_r1_release_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (ph == '0));

  // R3 / R4: a pulse starts only after a qualifying event
  a_r3_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pullup) |-> $past(wdt_ovf || (can_wake && pwr_down)));

  // R5: a wake-up outside power-down starts nothing
  a_r5_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (can_wake && !pwr_down && !wdt_ovf && !pin_pullup) |=> !pin_pullup);

  // R7: an internal pulse forces the core reset
  a_r7_pulse_forces_core: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pullup |=> core_rst);

  // R8: CAN reset only inside the core reset
  a_r8_can_within_core: assert property (@(posedge clk) disable iff (!rst_n)
    can_rst |-> core_rst);
endmodule

bind rst_seq_ctrl rst_seq_chk #(.OSC(OSC_PER_MC)) i_chk (
  .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .can_wake(can_wake),
  .pwr_down(pwr_down), .pin_pullup(pin_pullup), .core_rst(core_rst),
  .can_rst(can_rst)
);

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;
  localparam int WAKE_MC = 16;
  localparam int WAKE_L  = WAKE_MC * 12;

  logic clk = 1'b0;
  logic por_n, pin_rst, wdt_ovf, can_wake, pwr_down;
  logic pin_pullup, core_rst, can_rst, ale_force, psen_force;

  int total = 0, bad = 0, cyc;
  bit done = 0;
  int pc, pr, cr, cf, cc, sm;

  always #10 clk = ~clk;

  rst_seq_ctrl #(.WAKE_MC(WAKE_MC)) i_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .wdt_ovf(wdt_ovf),
    .can_wake(can_wake), .pwr_down(pwr_down), .pin_pullup(pin_pullup),
    .core_rst(core_rst), .can_rst(can_rst), .ale_force(ale_force),
    .psen_force(psen_force)
  );

  always @(posedge clk or negedge por_n)
    if (!por_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pin_pullup) begin pc++; if (pr < 0) pr = cyc; end
    if (core_rst && cr < 0) cr = cyc;
    if (!core_rst && cr >= 0 && cf < 0) cf = cyc;
    if (can_rst) cc++;
    if (ale_force != core_rst || psen_force != core_rst) sm++;
  end

  function automatic int nb(int t);
    int r = t;
    while (((r - 2) % 12) != 0) r++;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk); #1;
    pc = 0; pr = -1; cr = -1; cf = -1; cc = 0; sm = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_wdt(output int e);
    @(negedge clk); wdt_ovf = 1'b1; e = cyc + 1;
    @(negedge clk); wdt_ovf = 1'b0;
  endtask

  task automatic strobe_wake(input bit pd, output int e);
    @(negedge clk); can_wake = 1'b1; pwr_down = pd; e = cyc + 1;
    @(negedge clk); can_wake = 1'b0; pwr_down = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      finish_run();
    end
  end

  initial begin
    int e, e2, k;
    por_n = 1'b0; pin_rst = 1'b0; wdt_ovf = 1'b0; can_wake = 1'b0; pwr_down = 1'b0;
    idle(3);
    chk({pin_pullup, core_rst, can_rst, ale_force, psen_force} == 5'b0, "R10 por", 1, 0);
    @(negedge clk); por_n = 1'b1;
    clr(); idle(40);
    chk(pc + cc + sm == 0 && cr < 0, "R10 idle", pc + cc, 0);

    // R3 R1 R7 R8 R9: watchdog at every machine-cycle phase
    for (int ph = 0; ph < 12; ph++) begin
      clr(); idle(ph);
      strobe_wdt(e);
      idle(80);
      chk(pc == 36, "R3 wdt length", pc, 36);
      chk(pr == e, "R3 wdt start", pr, e);
      chk(cr == e + 1, "R7 wdt core rise", cr, e + 1);
      chk(cf == nb(e + 37), "R1 wdt release", cf, nb(e + 37));
      chk(cc == cf - cr, "R8 wdt can", cc, cf - cr);
      chk(sm == 0, "R9 strobes", sm, 0);
    end

    // R2: pin hold sweep around the threshold
    for (int n = 1; n <= 30; n++) begin
      clr();
      @(negedge clk); pin_rst = 1'b1; k = cyc + 1;
      idle(n); pin_rst = 1'b0;
      idle(60);
      if (n < 24) begin
        chk(cr < 0 && cc == 0, "R2 short pin", cr, -1);
      end else begin
        chk(cr == k + 26, "R2 pin core rise", cr, k + 26);
        chk(cf == nb(k + n + 3), "R7 pin release", cf, nb(k + n + 3));
        chk(cc == cf - cr, "R8 pin can", cc, cf - cr);
      end
      chk(pc == 0, "R2 pin no pullup", pc, 0);
    end

    // R4 R8: wake-up in power-down, pin held low throughout
    for (int ph = 0; ph < 3; ph++) begin
      clr(); idle(ph * 5);
      strobe_wake(1'b1, e);
      idle(WAKE_L + 40);
      chk(pc == WAKE_L, "R4 wake length", pc, WAKE_L);
      chk(cr == e + 1, "R7 wake core rise", cr, e + 1);
      chk(cf == nb(e + WAKE_L + 1), "R7 wake release", cf, nb(e + WAKE_L + 1));
      chk(cc == 0, "R8 wake spares can", cc, 0);
    end

    // R5: wake-up outside power-down
    clr();
    strobe_wake(1'b0, e);
    idle(60);
    chk(pc == 0 && cr < 0, "R5 wake ignored", pc, 0);

    // R6: watchdog then wake-up
    clr();
    strobe_wdt(e); idle(3);
    strobe_wake(1'b1, e2);
    idle(WAKE_L + 40);
    chk(e2 == e + 5, "R6 setup", e2, e + 5);
    chk(pc == 5 + WAKE_L, "R6 extend", pc, 5 + WAKE_L);
    chk(cf == nb(e2 + WAKE_L + 1), "R6 release", cf, nb(e2 + WAKE_L + 1));
    chk(cc == cf - cr, "R8 mixed can", cc, cf - cr);

    // R6 R8: wake-up then watchdog (no shortening, CAN reset joins)
    clr();
    strobe_wake(1'b1, e); idle(3);
    strobe_wdt(e2);
    idle(WAKE_L + 40);
    chk(pc == WAKE_L, "R6 keep longer", pc, WAKE_L);
    chk(cf == nb(e + WAKE_L + 1), "R6 release2", cf, nb(e + WAKE_L + 1));
    chk(cc == cf - e2, "R8 wdt joins can", cc, cf - e2);
    chk(sm == 0, "R9 strobes late", sm, 0);

    finish_run();
  end
endmodule